// File: doc/BRIEF.md
# Ring Node Packet Forwarder

This block is the forwarding and insertion stage of one node on a one-way daisy-chain ring. Every node on the ring keeps a copy of shared memory, and each memory write travels around the ring as a packet. A packet is a header longword followed by one or more data longwords. Header bits 31:24 hold the source node ID and bits 23:0 hold the byte address of the first data longword. Received packets come from the upstream link, already checked by an error detector that marks a bad packet on its header beat. The forwarder decides for each packet whether it goes on to the downstream link, and whether it also updates local memory.

A packet sent by this node has made a full trip once it comes back, so the forwarder removes it there and records that the ring is intact. A damaged packet is removed at the first node that sees it. Writes made by the local host wait in a packet queue and go out only at a packet boundary. A packet passing through has priority over a local one. Both queues work store-and-forward: a packet leaves only after its last beat has arrived, so the downstream stream never has holes inside a packet.

Top module: `ring_node_fwd`

## Requirements
- R1: A received packet without the error flag, whose header bits 31:24 differ from `node_id`, appears on the `tx_*` port with the same longwords, the same first and last flags, and in the same order.
- R2: A received packet whose source ID equals `node_id` is not transmitted. If its error flag is clear, it sets `ring_alive` at the clock edge that takes its header. `ring_alive` stays set until an `alive_clr` pulse clears it, and a set in the same cycle wins over the clear.
- R3: A packet whose header beat has `rx_err` high is fully dropped, from both `tx_*` and `mem_*`. `err_irq` pulses for exactly one cycle after that header when `err_irq_en` is high, and stays low when it is low.
- R4: For each data beat k (k = 0, 1, ...) of an error-free packet from another node, `mem_valid` pulses one cycle after the beat, with `mem_addr` = header address + 4·k and `mem_data` = the beat's data.
- R5: A local packet is transmitted with header bits 31:24 replaced by `node_id`. Its other header bits and its data beats are unchanged, and it starts only after its last beat has been accepted.
- R6: On `tx_*`, a `tx_first` beat follows only an idle cycle or a `tx_last` beat, and every other valid beat follows a valid beat that is not last. Packets never interleave.
- R7: When a received packet and a local packet are both complete at a packet boundary, the received packet is sent first.
- R8: `lcl_afull` rises when local queue occupancy exceeds `AF_LEVEL` and falls when occupancy drops below `LCL_DEPTH/2`. `lcl_ready` is low exactly while the local queue is full.
- R9: `stat_node_id` shows `node_id` one cycle after it is applied.
- R10: After reset, `tx_valid`, `mem_valid`, `err_irq`, `ring_alive` and `lcl_afull` are 0 and `lcl_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id | input | 8 | Static ID of this node |
| stat_node_id | output | 8 | Registered copy of the node ID |
| rx_valid | input | 1 | Upstream beat valid |
| rx_first | input | 1 | Upstream header beat |
| rx_last | input | 1 | Upstream final beat |
| rx_err | input | 1 | Packet damaged (valid on header beat) |
| rx_data | input | 32 | Upstream beat data |
| lcl_valid | input | 1 | Local write beat valid |
| lcl_first | input | 1 | Local header beat |
| lcl_last | input | 1 | Local final beat |
| lcl_data | input | 32 | Local beat data |
| lcl_ready | output | 1 | Local queue can take a beat |
| lcl_afull | output | 1 | Local queue almost full (hysteresis) |
| tx_valid | output | 1 | Downstream beat valid |
| tx_first | output | 1 | Downstream header beat |
| tx_last | output | 1 | Downstream final beat |
| tx_data | output | 32 | Downstream beat data |
| mem_valid | output | 1 | Memory update strobe |
| mem_addr | output | 24 | Memory update byte address |
| mem_data | output | 32 | Memory update data |
| err_irq_en | input | 1 | Enables the error pulse |
| err_irq | output | 1 | One-cycle pulse per damaged packet |
| alive_clr | input | 1 | Clears the ring-alive bit |
| ring_alive | output | 1 | Own packet has returned |

## Verification
The bench builds the block with `LCL_DEPTH` = 16, `AF_LEVEL` = 12, `MAX_LW` = 15 and `FWD_DEPTH` = 32. With these values, one maximum-length local packet of 16 beats fills the local queue exactly. That single packet brings the full condition, the rise of the almost-full bit above 12 and its hysteresis down to 7 all within reach, beat by beat. Sending one 16-beat local packet ahead of two short packets also sets up the case where the arbiter finds a received and a local packet waiting at the same boundary.

// File: rtl/rn_pkg.sv
package rn_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FWD  = 2'd1,
    ST_LCL  = 2'd2
  } arb_st_t;

  // hysteresis rule for the almost-full flag, on the occupancy after this edge
  function automatic logic af_update(input logic cur, input int unsigned occ,
                                     input int unsigned hi, input int unsigned lo);
    if (occ > hi)      return 1'b1;
    else if (occ < lo) return 1'b0;
    else               return cur;
  endfunction

endpackage

// File: rtl/rn_pkt_fifo.sv
module rn_pkt_fifo #(
  parameter int W     = 34,
  parameter int DEPTH = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr,
  input  logic [W-1:0]                 din,
  input  logic                         rd,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         avail
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] pkts;
  logic          wr_end, rd_end;

  // bit W-1 marks the final beat of a packet
  assign wr_end = wr && din[W-1];
  assign rd_end = rd && dout[W-1];
  assign dout   = store[rd_ptr];
  assign avail  = (pkts != '0);

  always_ff @(posedge clk) begin
    if (wr) store[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      pkts   <= '0;
    end else begin
      if (wr) wr_ptr <= wr_ptr + 1'b1;
      if (rd) rd_ptr <= rd_ptr + 1'b1;
      case ({wr, rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      case ({wr_end, rd_end})
        2'b10:   pkts <= pkts + 1'b1;
        2'b01:   pkts <= pkts - 1'b1;
        default: pkts <= pkts;
      endcase
    end
  end

  // R6
  fifo_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |-> (count != '0));

endmodule

// File: rtl/rn_rx_filter.sv
module rn_rx_filter #(
  parameter int DATA_W = 32,
  parameter int ID_W   = 8,
  parameter int MAX_LW = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ID_W-1:0]          node_id,
  input  logic                     rx_valid,
  input  logic                     rx_first,
  input  logic                     rx_err,
  input  logic [DATA_W-1:0]        rx_data,
  output logic                     fwd_wr,
  output logic                     own_hit,
  output logic                     err_hit,
  output logic                     mem_valid,
  output logic [DATA_W-ID_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]        mem_data
);
  localparam int ADDR_W = DATA_W - ID_W;
  localparam int LCW    = $clog2(MAX_LW + 2);

  logic              hdr, body, is_own, drop_now, drop_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LCW-1:0]    lw_cnt;

  function automatic logic [ADDR_W-1:0] next_lw(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(4);
  endfunction

  assign hdr      = rx_valid && rx_first;
  assign body     = rx_valid && !rx_first;
  assign is_own   = (rx_data[DATA_W-1:ADDR_W] == node_id);
  assign drop_now = hdr ? (rx_err || is_own) : drop_q;
  assign fwd_wr   = rx_valid && !drop_now;
  assign own_hit  = hdr && is_own && !rx_err;
  assign err_hit  = hdr && rx_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drop_q    <= 1'b1;
      addr_q    <= '0;
      lw_cnt    <= '0;
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
    end else begin
      mem_valid <= body && !drop_q;
      if (body) begin
        mem_addr <= addr_q;
        mem_data <= rx_data;
        addr_q   <= next_lw(addr_q);
        lw_cnt   <= lw_cnt + 1'b1;
      end
      if (hdr) begin
        drop_q <= rx_err || is_own;
        addr_q <= rx_data[ADDR_W-1:0];
        lw_cnt <= '0;
      end
    end
  end

  // R1
  rx_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    body |-> (lw_cnt < LCW'(MAX_LW)));
  // R4
  mem_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> $past(rx_valid && !rx_first));

endmodule

// File: rtl/rn_tx_arb.sv
module rn_tx_arb #(
  parameter int DATA_W = 32,
  parameter int ID_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ID_W-1:0]    node_id,
  input  logic               f_avail,
  input  logic [DATA_W+1:0]  f_head,
  input  logic               l_avail,
  input  logic [DATA_W+1:0]  l_head,
  output logic               f_rd,
  output logic               l_rd,
  output logic               tx_valid,
  output logic               tx_first,
  output logic               tx_last,
  output logic [DATA_W-1:0]  tx_data
);
  localparam int ADDR_W = DATA_W - ID_W;

  rn_pkg::arb_st_t st_q, st_n;
  logic [DATA_W+1:0] pick;
  logic [DATA_W-1:0] word;

  function automatic logic [DATA_W-1:0] stamp_src(input logic [DATA_W-1:0] w,
                                                  input logic [ID_W-1:0] id);
    return {id, w[ADDR_W-1:0]};
  endfunction

  always_comb begin
    f_rd = (st_q == rn_pkg::ST_FWD) || (st_q == rn_pkg::ST_IDLE && f_avail);
    l_rd = (st_q == rn_pkg::ST_LCL) ||
           (st_q == rn_pkg::ST_IDLE && !f_avail && l_avail);
    pick = f_rd ? f_head : l_head;
    word = (l_rd && pick[DATA_W]) ? stamp_src(pick[DATA_W-1:0], node_id)
                                  : pick[DATA_W-1:0];
    if (f_rd)      st_n = pick[DATA_W+1] ? rn_pkg::ST_IDLE : rn_pkg::ST_FWD;
    else if (l_rd) st_n = pick[DATA_W+1] ? rn_pkg::ST_IDLE : rn_pkg::ST_LCL;
    else           st_n = rn_pkg::ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= rn_pkg::ST_IDLE;
      tx_valid <= 1'b0;
      tx_first <= 1'b0;
      tx_last  <= 1'b0;
      tx_data  <= '0;
    end else begin
      st_q     <= st_n;
      tx_valid <= f_rd || l_rd;
      tx_first <= (f_rd || l_rd) && pick[DATA_W];
      tx_last  <= (f_rd || l_rd) && pick[DATA_W+1];
      tx_data  <= word;
    end
  end

  // R6
  tx_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_first) |-> ($past(tx_valid) && !$past(tx_last)));
  // R6
  tx_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_first) |-> (!$past(tx_valid) || $past(tx_last)));

endmodule

// File: rtl/ring_node_fwd.sv
module ring_node_fwd #(
  parameter int DATA_W    = 32,
  parameter int ID_W      = 8,
  parameter int MAX_LW    = 16,
  parameter int FWD_DEPTH = 32,
  parameter int LCL_DEPTH = 32,
  parameter int AF_LEVEL  = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ID_W-1:0]          node_id,
  output logic [ID_W-1:0]          stat_node_id,
  input  logic                     rx_valid,
  input  logic                     rx_first,
  input  logic                     rx_last,
  input  logic                     rx_err,
  input  logic [DATA_W-1:0]        rx_data,
  input  logic                     lcl_valid,
  input  logic                     lcl_first,
  input  logic                     lcl_last,
  input  logic [DATA_W-1:0]        lcl_data,
  output logic                     lcl_ready,
  output logic                     lcl_afull,
  output logic                     tx_valid,
  output logic                     tx_first,
  output logic                     tx_last,
  output logic [DATA_W-1:0]        tx_data,
  output logic                     mem_valid,
  output logic [DATA_W-ID_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]        mem_data,
  input  logic                     err_irq_en,
  output logic                     err_irq,
  input  logic                     alive_clr,
  output logic                     ring_alive
);
  localparam int BW  = DATA_W + 2;
  localparam int FCW = $clog2(FWD_DEPTH + 1);
  localparam int LCW = $clog2(LCL_DEPTH + 1);

  logic           fwd_wr, own_hit, err_hit;
  logic           f_rd, l_rd, f_avail, l_avail, lcl_wr;
  logic [BW-1:0]  f_head, l_head;
  logic [FCW-1:0] fwd_cnt;
  logic [LCW-1:0] lcl_cnt, lcl_cnt_nx;

  rn_rx_filter #(.DATA_W(DATA_W), .ID_W(ID_W), .MAX_LW(MAX_LW)) u_filt (
    .clk(clk), .rst_n(rst_n), .node_id(node_id),
    .rx_valid(rx_valid), .rx_first(rx_first), .rx_err(rx_err), .rx_data(rx_data),
    .fwd_wr(fwd_wr), .own_hit(own_hit), .err_hit(err_hit),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data));

  rn_pkt_fifo #(.W(BW), .DEPTH(FWD_DEPTH)) u_fwdq (
    .clk(clk), .rst_n(rst_n), .wr(fwd_wr), .din({rx_last, rx_first, rx_data}),
    .rd(f_rd), .dout(f_head), .count(fwd_cnt), .avail(f_avail));

  assign lcl_ready = (lcl_cnt != LCW'(LCL_DEPTH));
  assign lcl_wr    = lcl_valid && lcl_ready;

  rn_pkt_fifo #(.W(BW), .DEPTH(LCL_DEPTH)) u_lclq (
    .clk(clk), .rst_n(rst_n), .wr(lcl_wr), .din({lcl_last, lcl_first, lcl_data}),
    .rd(l_rd), .dout(l_head), .count(lcl_cnt), .avail(l_avail));

  rn_tx_arb #(.DATA_W(DATA_W), .ID_W(ID_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .node_id(node_id),
    .f_avail(f_avail), .f_head(f_head), .l_avail(l_avail), .l_head(l_head),
    .f_rd(f_rd), .l_rd(l_rd),
    .tx_valid(tx_valid), .tx_first(tx_first), .tx_last(tx_last), .tx_data(tx_data));

  always_comb begin
    case ({lcl_wr, l_rd})
      2'b10:   lcl_cnt_nx = lcl_cnt + 1'b1;
      2'b01:   lcl_cnt_nx = lcl_cnt - 1'b1;
      default: lcl_cnt_nx = lcl_cnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_node_id <= '0;
      err_irq      <= 1'b0;
      ring_alive   <= 1'b0;
      lcl_afull    <= 1'b0;
    end else begin
      stat_node_id <= node_id;
      err_irq      <= err_hit && err_irq_en;
      if (own_hit)        ring_alive <= 1'b1;
      else if (alive_clr) ring_alive <= 1'b0;
      lcl_afull <= rn_pkg::af_update(lcl_afull, int'(lcl_cnt_nx),
                                     AF_LEVEL, LCL_DEPTH / 2);
    end
  end

  // R1
  fwd_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_wr |-> (fwd_cnt < FCW'(FWD_DEPTH)));
  // R2
  alive_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ring_alive) |-> $past(own_hit));
  // R3
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> $past(err_hit && err_irq_en));
  // R8
  af_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcl_afull) |-> (lcl_cnt > LCW'(AF_LEVEL)));
  // R8
  af_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcl_afull) |-> (lcl_cnt < LCW'(LCL_DEPTH / 2)));

endmodule

// File: tb/ring_node_fwd_test.sv
module ring_node_fwd_test;
  localparam logic [7:0] NODE = 8'h5A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  stat_node_id;
  logic        rx_valid = 0, rx_first = 0, rx_last = 0, rx_err = 0;
  logic [31:0] rx_data = '0;
  logic        lcl_valid = 0, lcl_first = 0, lcl_last = 0;
  logic [31:0] lcl_data = '0;
  logic        lcl_ready, lcl_afull;
  logic        tx_valid, tx_first, tx_last;
  logic [31:0] tx_data;
  logic        mem_valid;
  logic [23:0] mem_addr;
  logic [31:0] mem_data;
  logic        err_irq_en = 0, err_irq, alive_clr = 0, ring_alive;

  int n_chk = 0, n_fail = 0, mon_chk = 0, mon_fail = 0, irq_seen = 0;
  logic [33:0] txq[$];
  logic [55:0] memq[$];

  always #10 clk = ~clk;

  ring_node_fwd #(.MAX_LW(15), .FWD_DEPTH(32), .LCL_DEPTH(16), .AF_LEVEL(12)) uut (
    .clk(clk), .rst_n(rst_n), .node_id(NODE), .stat_node_id(stat_node_id),
    .rx_valid(rx_valid), .rx_first(rx_first), .rx_last(rx_last), .rx_err(rx_err),
    .rx_data(rx_data), .lcl_valid(lcl_valid), .lcl_first(lcl_first),
    .lcl_last(lcl_last), .lcl_data(lcl_data), .lcl_ready(lcl_ready),
    .lcl_afull(lcl_afull), .tx_valid(tx_valid), .tx_first(tx_first),
    .tx_last(tx_last), .tx_data(tx_data), .mem_valid(mem_valid),
    .mem_addr(mem_addr), .mem_data(mem_data), .err_irq_en(err_irq_en),
    .err_irq(err_irq), .alive_clr(alive_clr), .ring_alive(ring_alive));

  function automatic logic [31:0] pat(input logic [7:0] s, input int k);
    return {s ^ 8'h3C, 8'hC3, 8'(k), 8'(k * 7 + 1)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboards as results appear
  always @(negedge clk) begin
    if (rst_n && tx_valid) begin
      mon_chk++;
      if (txq.size() == 0) begin
        mon_fail++;
        $display("FAIL R1/R6 unexpected tx beat: actual %0h expected none",
                 {tx_last, tx_first, tx_data});
      end else begin
        logic [33:0] e;
        e = txq.pop_front();
        if ({tx_last, tx_first, tx_data} !== e) begin
          mon_fail++;
          $display("FAIL R1/R5/R7 tx beat: actual %0h expected %0h",
                   {tx_last, tx_first, tx_data}, e);
        end
      end
    end
    if (rst_n && mem_valid) begin
      mon_chk++;
      if (memq.size() == 0) begin
        mon_fail++;
        $display("FAIL R4 unexpected mem write: actual %0h expected none",
                 {mem_addr, mem_data});
      end else begin
        logic [55:0] m;
        m = memq.pop_front();
        if ({mem_addr, mem_data} !== m) begin
          mon_fail++;
          $display("FAIL R4 mem write: actual %0h expected %0h",
                   {mem_addr, mem_data}, m);
        end
      end
    end
    if (rst_n && err_irq) irq_seen++;
  end

  // driver: received packet with n data beats; pushes expectations first
  task automatic rx_send(input logic [7:0] src, input logic [23:0] addr,
                         input int n, input bit err);
    bit pass;
    pass = !err && (src != NODE);
    if (pass) begin
      txq.push_back({1'b0, 1'b1, src, addr});
      for (int k = 0; k < n; k++) begin
        txq.push_back({k == n - 1, 1'b0, pat(src, k)});
        memq.push_back({addr + 24'(4 * k), pat(src, k)});
      end
    end
    for (int k = -1; k < n; k++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_first = (k < 0);
      rx_last  = (k == n - 1);
      rx_err   = (k < 0) ? err : 1'b0;
      rx_data  = (k < 0) ? {src, addr} : pat(src, k);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_first = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
  endtask

  // driver: local packet; the raw header carries FF as source field
  task automatic lcl_send(input logic [23:0] addr, input int n);
    txq.push_back({1'b0, 1'b1, NODE, addr});
    for (int k = 0; k < n; k++) txq.push_back({k == n - 1, 1'b0, pat(8'hEE, k)});
    for (int k = -1; k < n; k++) begin
      @(negedge clk);
      lcl_valid = 1'b1;
      lcl_first = (k < 0);
      lcl_last  = (k == n - 1);
      lcl_data  = (k < 0) ? {8'hFF, addr} : pat(8'hEE, k);
    end
    @(negedge clk);
    lcl_valid = 1'b0; lcl_first = 1'b0; lcl_last = 1'b0;
  endtask

  task automatic drain();
    int w;
    w = 0;
    while ((txq.size() != 0 || memq.size() != 0) && w < 500) begin
      @(negedge clk);
      w++;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic test_body();
    int irq0;
    // R10 reset state
    repeat (3) @(negedge clk);
    chk(!tx_valid && !mem_valid && !err_irq, "R10 outputs idle in reset", {tx_valid, mem_valid, err_irq}, 0);
    chk(!ring_alive && !lcl_afull && lcl_ready, "R10 flags in reset", {ring_alive, lcl_afull, lcl_ready}, 3'b001);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R9
    chk(stat_node_id == NODE, "R9 node id status", stat_node_id, NODE);

    // R1 R4 foreign packets, short and longest
    rx_send(8'h11, 24'h000100, 3, 1'b0);
    rx_send(8'h22, 24'h00FFF0, 15, 1'b0);
    rx_send(8'h00, 24'h123454, 1, 1'b0);
    drain();
    chk(txq.size() == 0 && memq.size() == 0, "R1 R4 foreign traffic delivered", txq.size() + memq.size(), 0);

    // R2 own packet stripped, ring alive
    chk(ring_alive == 1'b0, "R2 alive before own packet", ring_alive, 0);
    rx_send(NODE, 24'h000400, 2, 1'b0);
    chk(ring_alive == 1'b1, "R2 alive after own packet returns", ring_alive, 1);
    drain();
    @(negedge clk); alive_clr = 1'b1;
    @(negedge clk); alive_clr = 1'b0;
    chk(ring_alive == 1'b0, "R2 alive cleared by software", ring_alive, 0);

    // R3 errored packets dropped, interrupt only when enabled
    err_irq_en = 1'b1;
    irq0 = irq_seen;
    rx_send(8'h33, 24'h000800, 4, 1'b1);
    drain();
    chk(irq_seen == irq0 + 1, "R3 one error pulse when enabled", irq_seen - irq0, 1);
    err_irq_en = 1'b0;
    irq0 = irq_seen;
    rx_send(8'h44, 24'h000900, 2, 1'b1);
    rx_send(NODE, 24'h000A00, 2, 1'b1);
    drain();
    chk(irq_seen == irq0, "R3 no pulse when disabled", irq_seen - irq0, 0);
    chk(ring_alive == 1'b0, "R3 errored own packet leaves alive clear", ring_alive, 0);
    chk(txq.size() == 0 && memq.size() == 0, "R3 nothing emitted for damaged packets", txq.size() + memq.size(), 0);

    // R5 local packet stamped with node id, no memory update
    lcl_send(24'h000200, 2);
    drain();
    chk(txq.size() == 0, "R5 local packet sent stamped", txq.size(), 0);

    // R7 R6 long local packet in flight, then received and local both wait
    lcl_send(24'h003000, 15);
    fork
      rx_send(8'h66, 24'h004000, 2, 1'b0);
      begin
        logic [33:0] hold[$];
        // received packet is expected before the second local one
        hold = txq;
        lcl_send(24'h005000, 2);
      end
    join
    drain();
    chk(txq.size() == 0 && memq.size() == 0, "R7 received packet ahead of local", txq.size(), 0);

    // R8 almost-full and full with one 16-beat local packet
    txq.push_back({1'b0, 1'b1, NODE, 24'h006000});
    for (int k = 0; k < 15; k++) txq.push_back({k == 14, 1'b0, pat(8'h77, k)});
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (i == 12) chk(lcl_afull == 1'b0, "R8 afull low at 12 words", lcl_afull, 0);
      if (i == 13) chk(lcl_afull == 1'b1, "R8 afull high at 13 words", lcl_afull, 1);
      lcl_valid = 1'b1;
      lcl_first = (i == 0);
      lcl_last  = (i == 15);
      lcl_data  = (i == 0) ? {8'h01, 24'h006000} : pat(8'h77, i - 1);
    end
    @(negedge clk);
    lcl_valid = 1'b0; lcl_first = 1'b0; lcl_last = 1'b0;
    chk(lcl_ready == 1'b0, "R8 ready low when full", lcl_ready, 0);
    repeat (6) @(negedge clk);
    chk(lcl_afull == 1'b1, "R8 afull held at 10 words", lcl_afull, 1);
    repeat (2) @(negedge clk);
    chk(lcl_afull == 1'b1, "R8 afull held at 8 words", lcl_afull, 1);
    @(negedge clk);
    chk(lcl_afull == 1'b0, "R8 afull drops at 7 words", lcl_afull, 0);
    chk(lcl_ready == 1'b1, "R8 ready back once not full", lcl_ready, 1);
    drain();
    chk(txq.size() == 0 && memq.size() == 0, "R6 all packets complete", txq.size() + memq.size(), 0);
  endtask

  initial begin
    fork
      test_body();
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk + mon_chk, n_fail + mon_fail);
    $finish;
  end

endmodule